// File: doc/BRIEF.md
# Row-Buffered DRAM Model with Background Refresh

This block is a synthesizable behavioural model of a dynamic memory array with one row-wide static line placed in front of it. Row and column addresses share one set of address pins. A row strobe latches the row half and a falling column strobe latches the column half, which starts a read or a write. Chip select, write enable and output enable are all active low. Chip select comes from decoding outside the block.

The line holds the last row fetched by a read. A read to that row is served from the line after one cycle. A read to any other row waits for the slow array access, copies the whole row into the line, and then returns its word. Writes always go to the array. They also patch the line when it holds the same row, so the line never returns stale data.

A refresh sequencer runs in the background. At a fixed interval it refreshes the next row in turn. An access that arrives while a refresh is running is held until the refresh ends. Refresh does not change stored data, so the line stays valid across it.

Top module: `rowbuf_dram`

## Requirements
- R1: After reset `rd_valid_o` is 0, `rdata_o` is 0, `refresh_busy_o` is 0 and the line is empty, so the first read after reset is a miss.
- R2: With `cs_n_i` low, a cycle with `ras_n_i` low latches `addr_i` as the row. A cycle with `cas_n_i` low, following a cycle in which `cas_n_i` or `cs_n_i` was high, latches `addr_i[COL_BITS-1:0]` as the column together with `we_n_i` and `wdata_i`, and starts one access.
- R3: While `cs_n_i` is high, the row and column strobes have no effect: the latched row is kept and no access starts.
- R4: A read whose row matches the valid line raises `rd_valid_o` for exactly one cycle, after the first clock edge that follows the column-capture edge, with the addressed word on `rdata_o`.
- R5: A read that misses raises `rd_valid_o` MISS_CYC edges after the column-capture edge (4 by default) and leaves that row in the line.
- R6: A write stores `wdata_i` in the array, and a later read of that location returns it.
- R7: A write to the row held in the line also updates the line, so a later hit returns the new word.
- R8: `rdata_o` is 0 unless both `oe_n_i` and `cs_n_i` are low. When both are low, it shows the last word read.
- R9: A refresh starts every REF_PERIOD cycles when no access is running. `refresh_busy_o` is high for REF_CYC cycles. `refresh_row_o` names the row being refreshed and advances by one, modulo the row count, for each refresh.
- R10: An access captured during a refresh is served only after the refresh ends, and `rd_valid_o` is never high while `refresh_busy_o` is high. A hit captured in the cycle after a refresh starts returns REF_CYC edges after its capture.
- R11: A refresh neither invalidates the line nor changes stored data. After a refresh, a read to the line's row is still a hit.
- R12: A read to a row other than the line's row is a miss and replaces the line with the new row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ROW_BITS | Shared row/column address |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low, sampled with the column |
| oe_n_i | input | 1 | Output enable, active low |
| wdata_i | input | DATA_W | Write data, sampled with the column |
| rdata_o | output | DATA_W | Read data, gated by output enable and select |
| rd_valid_o | output | 1 | One-cycle pulse when read data is ready |
| refresh_busy_o | output | 1 | High while a refresh is running |
| refresh_row_o | output | ROW_BITS | Row being refreshed, or the next row to refresh |

## Verification
Assertions check on every cycle that read data never appears during a refresh or during a pending array fetch, and that a read-valid pulse lasts one cycle and implies a filled line. They also check that an access can start only from a selected column strobe, that the latched row holds while the chip is deselected, and that a pending refresh stays pending until it is granted. Latencies for hits, misses and accesses deferred by refresh, write coherence with the line, output gating, the refresh interval and row stepping, and the replacement of the line on a new row can only be shown by the bench's directed scenarios. Those scenarios compare the returned words and their arrival cycles against values computed from the requirements.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REF  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/rbd_strobe.sv
// Address demultiplexing: row latch and column-strobe edge detect.
module rbd_strobe #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROW_BITS-1:0] addr_i,
  input  logic                cs_n_i,
  input  logic                ras_n_i,
  input  logic                cas_n_i,
  input  logic                we_n_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                cap_o,
  output logic [ROW_BITS-1:0] cap_row_o,
  output logic [COL_BITS-1:0] cap_col_o,
  output logic                cap_we_o,
  output logic [DATA_W-1:0]   cap_wd_o
);
  logic [ROW_BITS-1:0] row_q;
  logic                cas_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      cas_hi_q <= 1'b1;
    end else begin
      if (!cs_n_i && !ras_n_i) row_q <= addr_i;
      cas_hi_q <= cs_n_i | cas_n_i;
    end
  end

  assign cap_o     = !cs_n_i && !cas_n_i && cas_hi_q;
  assign cap_row_o = row_q;
  assign cap_col_o = addr_i[COL_BITS-1:0];
  assign cap_we_o  = !we_n_i;
  assign cap_wd_o  = wdata_i;

  AST_ROW_HOLD_DESELECT: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> $stable(row_q)); // R3
endmodule

// File: rtl/rbd_cell_array.sv
// Array stored as one column-wide memory per column, so a whole row reads in one cycle.
module rbd_cell_array #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8
) (
  input  logic                                    clk,
  input  logic                                    wr_en_i,
  input  logic [ROW_BITS-1:0]                     wr_row_i,
  input  logic [COL_BITS-1:0]                     wr_col_i,
  input  logic [DATA_W-1:0]                       wr_data_i,
  input  logic [ROW_BITS-1:0]                     rd_row_i,
  output logic [(1<<COL_BITS)-1:0][DATA_W-1:0]    rd_q_o
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_col_i == COL_BITS'(c))) mem[wr_row_i] <= wr_data_i;
      q <= mem[rd_row_i];
    end

    assign rd_q_o[c] = q;
  end
endmodule

// File: rtl/rbd_refresh.sv
// Interval timer and row counter for background refresh.
module rbd_refresh #(
  parameter int ROW_BITS   = 4,
  parameter int REF_PERIOD = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ack_i,
  input  logic                done_i,
  output logic                req_o,
  output logic [ROW_BITS-1:0] row_o
);
  localparam int TW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

  logic [TW-1:0]       timer_q;
  logic                pend_q;
  logic [ROW_BITS-1:0] row_q;
  logic                tick;

  assign tick = (timer_q == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      pend_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      timer_q <= tick ? '0 : timer_q + 1'b1;
      if (tick)       pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      if (done_i) row_q <= row_q + 1'b1;
    end
  end

  assign req_o = pend_q;
  assign row_o = row_q;

  AST_REF_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i) |=> pend_q); // R9
endmodule

// File: rtl/rbd_ctrl.sv
// Access sequencer: line hit/miss, write coherence, refresh arbitration.
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8,
  parameter int MISS_CYC = 4,
  parameter int REF_CYC  = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cs_n_i,
  input  logic                                 cas_n_i,
  input  logic                                 cap_i,
  input  logic [ROW_BITS-1:0]                  cap_row_i,
  input  logic [COL_BITS-1:0]                  cap_col_i,
  input  logic                                 cap_we_i,
  input  logic [DATA_W-1:0]                    cap_wd_i,
  input  logic                                 ref_req_i,
  input  logic [ROW_BITS-1:0]                  ref_row_i,
  output logic                                 ref_ack_o,
  output logic                                 ref_done_o,
  input  logic [(1<<COL_BITS)-1:0][DATA_W-1:0] bank_q_i,
  output logic [ROW_BITS-1:0]                  bank_rd_row_o,
  output logic                                 bank_wr_en_o,
  output logic [ROW_BITS-1:0]                  bank_wr_row_o,
  output logic [COL_BITS-1:0]                  bank_wr_col_o,
  output logic [DATA_W-1:0]                    bank_wr_data_o,
  output logic [DATA_W-1:0]                    rd_data_o,
  output logic                                 rd_valid_o,
  output logic                                 ref_busy_o
);
  localparam int COLS = 1 << COL_BITS;
  localparam int MAXC = (MISS_CYC > REF_CYC) ? MISS_CYC : REF_CYC;
  localparam int CW   = $clog2(MAXC) + 1;

  ctl_state_e                      state_q;
  logic [CW-1:0]                   cnt_q;
  logic                            req_vld_q;
  logic [ROW_BITS-1:0]             req_row_q;
  logic [COL_BITS-1:0]             req_col_q;
  logic                            req_we_q;
  logic [DATA_W-1:0]               req_wd_q;
  logic [COLS-1:0][DATA_W-1:0]     line_q;
  logic [ROW_BITS-1:0]             line_row_q;
  logic                            line_vld_q;
  logic [DATA_W-1:0]               data_q;
  logic                            valid_q;
  logic                            line_hit;
  logic                            idle_free;

  assign line_hit  = line_vld_q && (line_row_q == req_row_q);
  assign idle_free = (state_q == ST_IDLE) && !ref_req_i;

  assign ref_ack_o      = (state_q == ST_IDLE) && ref_req_i;
  assign ref_done_o     = (state_q == ST_REF) && (cnt_q == CW'(REF_CYC - 1));
  assign bank_rd_row_o  = (state_q == ST_REF) ? ref_row_i : req_row_q;
  assign bank_wr_en_o   = idle_free && req_vld_q && req_we_q;
  assign bank_wr_row_o  = req_row_q;
  assign bank_wr_col_o  = req_col_q;
  assign bank_wr_data_o = req_wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      req_vld_q  <= 1'b0;
      req_row_q  <= '0;
      req_col_q  <= '0;
      req_we_q   <= 1'b0;
      req_wd_q   <= '0;
      line_q     <= '0;
      line_row_q <= '0;
      line_vld_q <= 1'b0;
      data_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ref_req_i) begin
            state_q <= ST_REF;
            cnt_q   <= '0;
          end else if (req_vld_q) begin
            if (req_we_q) begin
              if (line_hit) line_q[req_col_q] <= req_wd_q;
              req_vld_q <= 1'b0;
            end else if (line_hit) begin
              data_q    <= line_q[req_col_q];
              valid_q   <= 1'b1;
              req_vld_q <= 1'b0;
            end else begin
              state_q <= ST_ACT;
              cnt_q   <= CW'(1);
            end
          end
        end
        ST_ACT: begin
          if (cnt_q == CW'(MISS_CYC - 1)) begin
            line_q     <= bank_q_i;
            line_row_q <= req_row_q;
            line_vld_q <= 1'b1;
            data_q     <= bank_q_i[req_col_q];
            valid_q    <= 1'b1;
            req_vld_q  <= 1'b0;
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REF: begin
          if (cnt_q == CW'(REF_CYC - 1)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (cap_i && !req_vld_q) begin
        req_vld_q <= 1'b1;
        req_row_q <= cap_row_i;
        req_col_q <= cap_col_i;
        req_we_q  <= cap_we_i;
        req_wd_q  <= cap_wd_i;
      end
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;
  assign ref_busy_o = (state_q == ST_REF);

  AST_NO_DATA_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REF) |-> !valid_q); // R10
  AST_MISS_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACT) |-> !valid_q); // R5
  AST_VALID_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> line_vld_q); // R1
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R4
  AST_ACCESS_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    $rose(req_vld_q) |-> $past(!cs_n_i && !cas_n_i)); // R3
endmodule

// File: rtl/rowbuf_dram.sv
module rowbuf_dram #(
  parameter int ROW_BITS   = 4,
  parameter int COL_BITS   = 3,
  parameter int DATA_W     = 8,
  parameter int MISS_CYC   = 4,
  parameter int REF_CYC    = 3,
  parameter int REF_PERIOD = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROW_BITS-1:0] addr_i,
  input  logic                cs_n_i,
  input  logic                ras_n_i,
  input  logic                cas_n_i,
  input  logic                we_n_i,
  input  logic                oe_n_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rd_valid_o,
  output logic                refresh_busy_o,
  output logic [ROW_BITS-1:0] refresh_row_o
);
  localparam int COLS = 1 << COL_BITS;

  logic                        cap;
  logic [ROW_BITS-1:0]         cap_row;
  logic [COL_BITS-1:0]         cap_col;
  logic                        cap_we;
  logic [DATA_W-1:0]           cap_wd;
  logic                        ref_req, ref_ack, ref_done;
  logic [ROW_BITS-1:0]         ref_row;
  logic [COLS-1:0][DATA_W-1:0] bank_q;
  logic [ROW_BITS-1:0]         bank_rd_row, bank_wr_row;
  logic                        bank_wr_en;
  logic [COL_BITS-1:0]         bank_wr_col;
  logic [DATA_W-1:0]           bank_wr_data;
  logic [DATA_W-1:0]           rd_data;

  rbd_strobe #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .wdata_i(wdata_i), .cap_o(cap),
    .cap_row_o(cap_row), .cap_col_o(cap_col), .cap_we_o(cap_we), .cap_wd_o(cap_wd)
  );

  rbd_refresh #(.ROW_BITS(ROW_BITS), .REF_PERIOD(REF_PERIOD)) u_refresh (
    .clk(clk), .rst(rst), .ack_i(ref_ack), .done_i(ref_done),
    .req_o(ref_req), .row_o(ref_row)
  );

  rbd_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en_i(bank_wr_en), .wr_row_i(bank_wr_row), .wr_col_i(bank_wr_col),
    .wr_data_i(bank_wr_data), .rd_row_i(bank_rd_row), .rd_q_o(bank_q)
  );

  rbd_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W),
             .MISS_CYC(MISS_CYC), .REF_CYC(REF_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .cs_n_i(cs_n_i), .cas_n_i(cas_n_i), .cap_i(cap),
    .cap_row_i(cap_row), .cap_col_i(cap_col), .cap_we_i(cap_we), .cap_wd_i(cap_wd),
    .ref_req_i(ref_req), .ref_row_i(ref_row), .ref_ack_o(ref_ack), .ref_done_o(ref_done),
    .bank_q_i(bank_q), .bank_rd_row_o(bank_rd_row), .bank_wr_en_o(bank_wr_en),
    .bank_wr_row_o(bank_wr_row), .bank_wr_col_o(bank_wr_col), .bank_wr_data_o(bank_wr_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid_o), .ref_busy_o(refresh_busy_o)
  );

  assign rdata_o       = (!oe_n_i && !cs_n_i) ? rd_data : '0;
  assign refresh_row_o = ref_row;
endmodule

// File: tb/sim_rowbuf_dram.sv
module sim_rowbuf_dram;
  localparam int ROW_BITS = 4;
  localparam int COL_BITS = 3;
  localparam int DATA_W   = 8;
  localparam int MISS_CYC = 4;
  localparam int REF_CYC  = 3;
  localparam int PERIOD   = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst;
  logic [ROW_BITS-1:0] addr;
  logic                cs_n, ras_n, cas_n, we_n, oe_n;
  logic [DATA_W-1:0]   wdata, rdata;
  logic                rd_valid, refresh_busy;
  logic [ROW_BITS-1:0] refresh_row;

  rowbuf_dram #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W),
                .MISS_CYC(MISS_CYC), .REF_CYC(REF_CYC), .REF_PERIOD(PERIOD)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .oe_n_i(oe_n), .wdata_i(wdata),
    .rdata_o(rdata), .rd_valid_o(rd_valid), .refresh_busy_o(refresh_busy),
    .refresh_row_o(refresh_row)
  );

  int checks = 0;
  int errors = 0;

  function automatic int pat(int r, int c);
    return ((r * 16 + c) ^ 8'h5A) & 8'hFF;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_row(int r);
    @(negedge clk);
    cs_n = 1'b0; ras_n = 1'b0; addr = ROW_BITS'(r);
    @(negedge clk);
    ras_n = 1'b1;
  endtask

  task automatic wait_read(output int lat, output int dat);
    lat = 0; dat = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (rd_valid) begin lat = i; dat = int'(rdata); break; end
    end
  endtask

  task automatic cas_read(int c, output int lat, output int dat);
    @(negedge clk);
    addr = ROW_BITS'(c); we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    cas_n = 1'b1;
    wait_read(lat, dat);
  endtask

  task automatic cas_write(int c, int d);
    @(negedge clk);
    addr = ROW_BITS'(c); we_n = 1'b0; wdata = DATA_W'(d); cas_n = 1'b0;
    @(negedge clk);
    cas_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic sync_ref();
    while (!refresh_busy) @(negedge clk);
    while (refresh_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    chk(rdata == '0, "R1 rdata after reset", int'(rdata), 0);
    chk(refresh_busy == 1'b0, "R1 refresh idle after reset", int'(refresh_busy), 0);
  endtask

  task automatic t_fill();
    for (int r = 2; r <= 3; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) cas_write(c, pat(r, c));
    end
  endtask

  task automatic t_miss_then_hit();
    int lat, dat;
    sync_ref();
    open_row(2);
    cas_read(5, lat, dat);
    chk(lat == MISS_CYC, "R1 R5 first read is a miss", lat, MISS_CYC);
    chk(dat == pat(2, 5), "R2 R6 miss data", dat, pat(2, 5));
    cas_read(1, lat, dat);
    chk(lat == 1, "R4 hit latency", lat, 1);
    chk(dat == pat(2, 1), "R2 R4 hit data", dat, pat(2, 1));
    cas_read(7, lat, dat);
    chk(lat == 1 && dat == pat(2, 7), "R4 second hit", dat, pat(2, 7));
  endtask

  task automatic t_deselect();
    int seen, lat, dat;
    seen = 0;
    sync_ref();
    @(negedge clk);
    cs_n = 1'b1; ras_n = 1'b0; addr = 4'd3;
    @(negedge clk);
    ras_n = 1'b1; addr = 4'd0; we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    cas_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rd_valid) seen++;
    end
    chk(seen == 0, "R3 no access while deselected", seen, 0);
    cs_n = 1'b0;
    cas_read(4, lat, dat);
    chk(lat == 1, "R3 row kept, still a hit", lat, 1);
    chk(dat == pat(2, 4), "R3 row latch unchanged", dat, pat(2, 4));
  endtask

  task automatic t_output_gate();
    int exp;
    exp = pat(2, 4);
    @(negedge clk); oe_n = 1'b1; #1;
    chk(rdata == '0, "R8 output off with oe_n high", int'(rdata), 0);
    @(negedge clk); oe_n = 1'b0; cs_n = 1'b1; #1;
    chk(rdata == '0, "R8 output off with cs_n high", int'(rdata), 0);
    @(negedge clk); cs_n = 1'b0; #1;
    chk(int'(rdata) == exp, "R8 output back when enabled", int'(rdata), exp);
  endtask

  task automatic t_write_hit();
    int lat, dat;
    sync_ref();
    open_row(2);
    cas_write(3, 8'hC3);
    cas_read(3, lat, dat);
    chk(lat == 1, "R7 write kept line valid", lat, 1);
    chk(dat == 8'hC3, "R7 hit returns written word", dat, 8'hC3);
  endtask

  task automatic t_write_miss();
    int lat, dat;
    sync_ref();
    open_row(5);
    cas_write(2, 8'h3C);
    cas_read(2, lat, dat);
    chk(lat == MISS_CYC, "R12 other row misses", lat, MISS_CYC);
    chk(dat == 8'h3C, "R6 array holds written word", dat, 8'h3C);
    open_row(2);
    cas_read(3, lat, dat);
    chk(lat == MISS_CYC, "R12 line replaced, old row misses", lat, MISS_CYC);
    chk(dat == 8'hC3, "R6 R7 array updated on hit write", dat, 8'hC3);
  endtask

  task automatic t_refresh_period();
    int r0, len, gap;
    while (refresh_busy) @(negedge clk);
    while (!refresh_busy) @(negedge clk);
    r0 = int'(refresh_row); len = 0; gap = 0;
    while (refresh_busy) begin len++; gap++; @(negedge clk); end
    while (!refresh_busy) begin gap++; @(negedge clk); end
    chk(len == REF_CYC, "R9 refresh length", len, REF_CYC);
    chk(gap == PERIOD, "R9 refresh interval", gap, PERIOD);
    chk(int'(refresh_row) == ((r0 + 1) % 16), "R9 row steps by one", int'(refresh_row), (r0 + 1) % 16);
  endtask

  task automatic t_refresh_defer();
    int lat, dat;
    sync_ref();
    open_row(2);
    cas_read(6, lat, dat);
    chk(lat == 1, "R11 line still valid before refresh", lat, 1);
    while (!refresh_busy) @(negedge clk);
    addr = 4'd0; we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    cas_n = 1'b1;
    wait_read(lat, dat);
    chk(lat == REF_CYC, "R10 access held until refresh ends", lat, REF_CYC);
    chk(dat == pat(2, 0), "R10 deferred read data", dat, pat(2, 0));
    cas_read(1, lat, dat);
    chk(lat == 1, "R11 hit after refresh", lat, 1);
    open_row(3);
    cas_read(6, lat, dat);
    chk(dat == pat(3, 6), "R11 data kept across refresh", dat, pat(3, 6));
  endtask

  initial begin
    rst = 1'b1; addr = '0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
    we_n = 1'b1; oe_n = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_miss_then_hit();
    t_deselect();
    t_output_gate();
    t_write_hit();
    t_write_miss();
    t_refresh_period();
    t_refresh_defer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule